// File: doc/BRIEF.md
# Critical-Word-First Line Fill Cache

This block is a small direct-mapped, read-only cache for an instruction-style processor port. Each line holds four 32-bit words and carries one valid bit for the whole line. On a miss, the controller asks the backing memory for the word the processor wanted. It releases the processor as soon as that word is in the line buffer. It then fetches the other three words in wrap-around order while the processor keeps running.

The processor side is a request/address/ready handshake. The processor holds `cpu_req` and `cpu_addr` until it sees `cpu_ready`, and `cpu_rdata` is valid in that same cycle. The memory side fetches one word at a time. A request pulse on `mem_req` is answered by `mem_valid` in the next cycle, so each word costs two cycles.

While a fill runs, an access to the next word in sequence is served from the line buffer if that word has already arrived. If it has not arrived, the access waits only for that word. Any other access waits until the whole line is in. Two outputs are provided for verification: a fill-busy flag and a stall-cycle counter.

Top module: `cwf_cache`

## Requirements
- R1: After reset no line is valid, `fill_busy` is 0, `stall_cycles` is 0 and `mem_req` is 0, so the first access of any address misses.
- R2: When no fill is running, a request whose line index holds a valid line with a matching tag completes in the same cycle, and `cpu_rdata` holds the stored word.
- R3: A request that misses in cycle t starts a fill. `fill_busy` rises at t+1, and `mem_req` at t+1 carries the requested word address. The processor gets `cpu_ready` with that word at t+3.
- R4: After the critical word, the fill requests words (c+1), (c+2) and (c+3) modulo 4 of the same line, where c is the 2-bit word offset `cpu_addr[1:0]`. Requests go out at t+3, t+5 and t+7, one every two cycles, with never two in adjacent cycles.
- R5: During a fill, a request whose address equals the previous served address plus one, inside the line being filled, completes in the same cycle if its word has already arrived.
- R6: During a fill, such a sequential request for a word not yet arrived stalls. It completes in the cycle after that word's `mem_valid`.
- R7: During a fill, any other request (not sequential, or in another line) stalls until `fill_busy` has fallen. It is then looked up as in R2 or R3. No new fill starts while one is running.
- R8: `fill_busy` stays high from t+1 through t+8, which is the cycle of the last word's arrival. The line becomes valid, and hits as in R2, from t+9.
- R9: `stall_cycles` increments by one after every cycle with `cpu_req` high and `cpu_ready` low, and holds otherwise.
- R10: `mem_req` is asserted only while `fill_busy` is high.
- R11: The cache is direct-mapped on address bits [5:2]. A miss to a different tag replaces the line, so an access to the old tag misses again afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor read request, held until ready |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| mem_req | output | 1 | One-cycle word fetch request |
| mem_addr | output | ADDR_W | Word address of the fetch (line part held during a fill) |
| mem_valid | input | 1 | Fetched word present, one cycle after mem_req |
| mem_rdata | input | DATA_W | Fetched word |
| fill_busy | output | 1 | A line fill is in progress |
| stall_cycles | output | CNT_W | Count of stalled request cycles |

## Verification
Two events can land in the same cycle: a background word being written into the line buffer, and the processor reading a word already in that same line. The bench provokes this by issuing sequential accesses right after the critical word is released, with short idle gaps placed so that reads fall on `mem_valid` cycles. A second case is a stalled request that resolves in the cycle right after the last word arrives, when the line turns valid. This is provoked by non-sequential accesses late in a fill. A behavioural model built on cycle offsets from the miss decides the expected ready, data, fetch address, busy flag and stall count for every cycle. Directed latency checks pin down the release, wait and replacement timings.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned OFF_W      = $clog2(LINE_WORDS);
    typedef logic [OFF_W-1:0] woff_t;
endpackage

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IX_W-1:0]   wr_ix,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IX_W-1:0]   rd_ix,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_ix] <= wr_data;
    end

    assign rd_data = words_q[rd_ix];
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
    import cwf_pkg::*;
#(
    parameter int unsigned LINE_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LINE_W-1:0]     start_line,
    input  woff_t                 start_word,
    input  logic                  mem_valid,
    output logic                  busy,
    output logic [LINE_WORDS-1:0] filled,
    output logic [LINE_W-1:0]     line,
    output logic                  mem_req,
    output logic [LINE_W+OFF_W-1:0] mem_addr,
    output logic                  wr_en,
    output woff_t                 wr_word,
    output logic                  done
);
    typedef struct packed {
        logic                  busy;
        logic                  pend;
        woff_t                 word;
        woff_t                 cnt;
        logic [LINE_WORDS-1:0] filled;
        logic [LINE_W-1:0]     line;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d  = fill_q;
        mem_req = fill_q.busy && !fill_q.pend;
        wr_en   = 1'b0;
        done    = 1'b0;
        if (start && !fill_q.busy) begin
            fill_d.busy   = 1'b1;
            fill_d.pend   = 1'b0;
            fill_d.word   = start_word;
            fill_d.cnt    = '0;
            fill_d.filled = '0;
            fill_d.line   = start_line;
        end else if (fill_q.busy) begin
            if (!fill_q.pend) begin
                fill_d.pend = 1'b1;
            end else if (mem_valid) begin
                wr_en                      = 1'b1;
                fill_d.filled[fill_q.word] = 1'b1;
                fill_d.word                = fill_q.word + woff_t'(1);
                fill_d.cnt                 = fill_q.cnt + woff_t'(1);
                fill_d.pend                = 1'b0;
                if (fill_q.cnt == woff_t'(LINE_WORDS - 1)) begin
                    fill_d.busy = 1'b0;
                    done        = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign busy     = fill_q.busy;
    assign filled   = fill_q.filled;
    assign line     = fill_q.line;
    assign mem_addr = {fill_q.line, fill_q.word};
    assign wr_word  = fill_q.word;
endmodule

// File: rtl/cwf_cache.sv
module cwf_cache
    import cwf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LINES  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fill_busy,
    output logic [CNT_W-1:0]  stall_cycles
);
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;
    localparam int unsigned TAG_W  = LINE_W - IDX_W;
    localparam int unsigned DEPTH  = LINES * LINE_WORDS;

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tags;
        logic [ADDR_W-1:0]           nxt_addr;
        logic [CNT_W-1:0]            stalls;
    } top_t;

    top_t top_d, top_q;

    logic [LINE_W-1:0]     req_line;
    logic [IDX_W-1:0]      req_idx;
    logic [TAG_W-1:0]      req_tag;
    woff_t                 req_word;
    logic                  f_busy, f_wr, f_done;
    logic [LINE_WORDS-1:0] f_filled;
    logic [LINE_W-1:0]     f_line;
    woff_t                 f_word;
    logic                  lookup_hit, early_ok, start_fill;

    assign req_line = cpu_addr[ADDR_W-1:OFF_W];
    assign req_word = cpu_addr[OFF_W-1:0];
    assign req_idx  = req_line[IDX_W-1:0];
    assign req_tag  = req_line[LINE_W-1:IDX_W];

    assign lookup_hit = top_q.valid[req_idx] && (top_q.tags[req_idx] == req_tag);
    assign early_ok   = (req_line == f_line) && (cpu_addr == top_q.nxt_addr)
                        && f_filled[req_word];
    assign cpu_ready  = cpu_req && (f_busy ? early_ok : lookup_hit);
    assign start_fill = cpu_req && !f_busy && !lookup_hit;

    always_comb begin
        top_d = top_q;
        if (start_fill) begin
            top_d.nxt_addr       = cpu_addr;
            top_d.valid[req_idx] = 1'b0;
        end
        if (cpu_ready && f_busy) top_d.nxt_addr = cpu_addr + ADDR_W'(1);
        if (cpu_req && !cpu_ready) top_d.stalls = top_q.stalls + CNT_W'(1);
        if (f_done) begin
            top_d.valid[f_line[IDX_W-1:0]] = 1'b1;
            top_d.tags[f_line[IDX_W-1:0]]  = f_line[LINE_W-1:IDX_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    cwf_fill_ctrl #(.LINE_W(LINE_W)) fill_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_fill),
        .start_line (req_line),
        .start_word (req_word),
        .mem_valid  (mem_valid),
        .busy       (f_busy),
        .filled     (f_filled),
        .line       (f_line),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .wr_en      (f_wr),
        .wr_word    (f_word),
        .done       (f_done)
    );

    cwf_line_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
        .clk     (clk),
        .wr_en   (f_wr),
        .wr_ix   ({f_line[IDX_W-1:0], f_word}),
        .wr_data (mem_rdata),
        .rd_ix   ({req_idx, req_word}),
        .rd_data (cpu_rdata)
    );

    assign fill_busy    = f_busy;
    assign stall_cycles = top_q.stalls;
endmodule

// File: rtl/cwf_cache_chk.sv
module cwf_cache_chk
    import cwf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              fill_busy,
    input logic [CNT_W-1:0]  stall_cycles
);
    assert_req_in_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fill_busy);

    assert_spaced_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_fill_from_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy) |-> $past(cpu_req && !cpu_ready));

    assert_early_in_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && fill_busy) |-> (cpu_addr[ADDR_W-1:OFF_W] == mem_addr[ADDR_W-1:OFF_W]));

    assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    assert_stall_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready) |=> (stall_cycles == $past(stall_cycles) + CNT_W'(1)));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && !cpu_ready) |=> $stable(stall_cycles));
endmodule

bind cwf_cache cwf_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_addr     (cpu_addr),
    .cpu_ready    (cpu_ready),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .fill_busy    (fill_busy),
    .stall_cycles (stall_cycles)
);

// File: tb/cwf_cache_tb_top.sv
`timescale 1ns/1ps
module cwf_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        fill_busy;
    logic [15:0] stall_cycles;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cwf_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .fill_busy(fill_busy), .stall_cycles(stall_cycles)
    );

    function automatic logic [31:0] pat(input logic [15:0] a);
        return {a ^ 16'hC3A5, a};
    endfunction

    // backing memory: answers one cycle after each request
    always @(posedge clk) begin
        mem_valid <= mem_req && rst_n;
        mem_rdata <= pat(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, timed by offsets from the miss cycle
    int          cyc = 0;
    bit          f_act = 0;
    int          t0 = 0;
    int          fline = 0;
    int          crit = 0;
    int          nxt = 0;
    int          scount = 0;
    bit          mv [16];
    int          mt [16];

    always @(negedge clk) begin
        if (rst_n) begin
            bit    rdy_e, hit, mreq_e;
            int    idx, tg, k, w;
            string tag;
            idx = (int'(cpu_addr) >> 2) & 15;
            tg  = int'(cpu_addr) >> 6;
            w   = int'(cpu_addr) & 3;
            hit = mv[idx] && (mt[idx] == tg);
            rdy_e = 1'b0;
            tag = "R2";
            if (cpu_req) begin
                if (f_act) begin
                    k = (w - crit) & 3;
                    if (((int'(cpu_addr) >> 2) == fline) && (int'(cpu_addr) == nxt)) begin
                        rdy_e = (cyc >= t0 + 3 + 2 * k);
                        tag = rdy_e ? "R5" : "R6";
                    end else begin
                        tag = "R7";
                    end
                end else begin
                    rdy_e = hit;
                    tag = hit ? "R2" : "R3";
                end
            end
            mreq_e = f_act && (cyc <= t0 + 7) && (((cyc - t0 - 1) % 2) == 0);
            chk(cpu_ready == rdy_e, tag, cpu_ready, rdy_e);
            if (cpu_ready && rdy_e)
                chk(cpu_rdata == pat(cpu_addr), "R2 data", cpu_rdata, pat(cpu_addr));
            chk(fill_busy == f_act, "R8", fill_busy, f_act);
            chk(mem_req == mreq_e, "R10", mem_req, mreq_e);
            if (mem_req && mreq_e)
                chk(int'(mem_addr) == ((fline << 2) | ((crit + (cyc - t0 - 1) / 2) & 3)),
                    "R4", mem_addr, (fline << 2) | ((crit + (cyc - t0 - 1) / 2) & 3));
            chk(int'(stall_cycles) == scount, "R9", stall_cycles, scount);
            // advance model
            if (cpu_req && !rdy_e) scount = (scount + 1) & 16'hFFFF;
            if (f_act) begin
                if (rdy_e) nxt = int'(cpu_addr) + 1;
                if (cyc == t0 + 8) begin
                    mv[fline & 15] = 1'b1;
                    mt[fline & 15] = fline >> 4;
                    f_act = 1'b0;
                end
            end else if (cpu_req && !hit) begin
                f_act = 1'b1;
                t0 = cyc;
                fline = int'(cpu_addr) >> 2;
                crit = w;
                nxt = int'(cpu_addr);
                mv[idx] = 1'b0;
            end
            cyc++;
        end
    end

    task automatic access(input logic [15:0] a, output int lat);
        cpu_req = 1'b1;
        cpu_addr = a;
        lat = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            lat++;
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            if (!fill_busy) break;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R3 watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int lat;
        logic [15:0] lfsr;
        logic [15:0] prev;
        for (int i = 0; i < 16; i++) begin
            mv[i] = 1'b0;
            mt[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(fill_busy == 1'b0, "R1 busy", fill_busy, 0);
        chk(stall_cycles == 16'd0, "R1 stalls", stall_cycles, 0);
        chk(mem_req == 1'b0, "R1 memreq", mem_req, 0);
        @(posedge clk);
        #1;

        // first miss, then sequential access to a word not yet fetched
        access(16'h0012, lat); chk(lat == 3, "R3 release", lat, 3);
        access(16'h0013, lat); chk(lat == 1, "R6 wait word", lat, 1);
        wait_idle();
        access(16'h0013, lat); chk(lat == 0, "R8 hit", lat, 0);

        // sequential hit on a fetched word, then a non-sequential stall
        access(16'h0040, lat); chk(lat == 3, "R3 release", lat, 3);
        idle(2);
        access(16'h0041, lat); chk(lat == 0, "R5 early hit", lat, 0);
        access(16'h0043, lat); chk(lat == 2, "R7 stall to end", lat, 2);
        access(16'h0041, lat); chk(lat == 0, "R2 hit", lat, 0);

        // replacement in a direct-mapped slot
        access(16'h0440, lat); chk(lat == 3, "R11 conflict miss", lat, 3);
        wait_idle();
        access(16'h0040, lat); chk(lat == 3, "R11 old tag misses", lat, 3);
        wait_idle();

        // wrap order from the last word of a line
        access(16'h0017, lat); chk(lat == 3, "R4 wrap start", lat, 3);
        access(16'h0100, lat);
        wait_idle();

        // mixed traffic
        lfsr = 16'hACE1;
        prev = 16'h0000;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) prev = prev + 16'd1;
            else         prev = {6'd0, lfsr[10:1]};
            access(prev, lat);
            if (lfsr[3:2] == 2'b00) idle(int'(lfsr[5:4]));
        end
        wait_idle();
        idle(2);
        summary();
        $finish;
    end
endmodule